// File: doc/BRIEF.md
# Single-Cycle Fully Associative Micro Translation Cache

This block is a small first-level address translation cache placed next to one port of a processor core (instruction fetch or data access). Every cycle it can accept one lookup carrying a virtual address, the running address space identifier, a secure-world table tag, the kind of access and the privilege level. It compares the virtual page number against all stored entries at once. One clock edge later it reports hit or miss, the translated physical address, and an abort flag when a hit entry forbids the access.

A miss raises a one-cycle refill request that carries the missing virtual address toward a larger second-level translation cache. That cache later returns a complete entry on the fill port. The fill goes to a free slot if one exists; otherwise a victim is chosen by a rotating pointer or by a linear feedback shift register, depending on a mode input. Software-driven maintenance can drop every entry at once, or drop all non-global entries that belong to one address space identifier. Each entry holds one of four page sizes, so a single entry can map a large region.

Top module: `utlb_top`

## Requirements
- R1: After reset no entry is valid, `rsp_valid` and `rf_req` are low, and every lookup misses.
- R2: A lookup presented in cycle N is answered in cycle N+1 through `rsp_valid`, `rsp_hit`, `rsp_abort` and `rsp_paddr`. A miss also raises `rf_req` in that same cycle, with `rf_req_vaddr` equal to the looked-up address. A hit leaves `rf_req` low.
- R3: A non-global entry hits only when its address space identifier equals `lk_asid` and its secure-world tag equals `lk_nonsec`.
- R4: A global entry (`fill_global`=1) hits for any `lk_asid`, but its secure-world tag must still equal `lk_nonsec`.
- R5: Size code `fill_size` 0/1/2/3 selects a 4 KB/64 KB/1 MB/16 MB page. Virtual bits above the page offset are compared and replaced by the entry's frame bits. Offset bits pass from the virtual address unchanged.
- R6: `fill_perm` bit0=readable, bit1=writable, bit2=execute-never, bit3=privileged-only. `lk_kind` 0 or 3 is a load, which needs bit0. Kind 1 is a store, which needs bit1. Kind 2 is a fetch, which needs bit2 clear. An access with `lk_priv`=0 to a privileged-only entry fails. A failing hit raises `rsp_abort`; a miss never does.
- R7: A fill is usable by a lookup in the next cycle. It takes the lowest-numbered invalid slot while any slot is free, so no valid entry is evicted.
- R8: With `cfg_rand_repl`=0 and every slot valid, fills evict slots in rotating order starting at slot 0 after reset.
- R9: With `cfg_rand_repl`=1 and every slot valid, a fill replaces exactly one existing entry, chosen by a free-running LFSR.
- R10: `inv_all` makes every entry invalid in one cycle.
- R11: `inv_asid_valid` invalidates, in one cycle, every non-global entry whose identifier equals `inv_asid`. Global entries and other identifiers are kept.
- R12: A fill presented in the same cycle as either invalidate is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rand_repl | input | 1 | Victim mode: 0 rotating, 1 LFSR |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address space identifier |
| lk_nonsec | input | 1 | Secure-world table tag of the request |
| lk_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| lk_priv | input | 1 | Requester is privileged |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_abort | output | 1 | Hit with a permission violation |
| rsp_paddr | output | 32 | Translated physical address (zero on miss) |
| rf_req | output | 1 | Refill request toward the second level |
| rf_req_vaddr | output | 32 | Address that missed |
| fill_valid | input | 1 | Refill entry present |
| fill_vpn | input | 20 | Virtual page number (4 KB units) |
| fill_ppn | input | 20 | Physical frame number (4 KB units) |
| fill_size | input | 2 | Page size code |
| fill_asid | input | 8 | Entry address space identifier |
| fill_nonsec | input | 1 | Entry secure-world tag |
| fill_global | input | 1 | Entry matches any identifier |
| fill_perm | input | 4 | Permission bits (see R6) |
| inv_all | input | 1 | Invalidate every entry |
| inv_asid_valid | input | 1 | Invalidate by identifier |
| inv_asid | input | 8 | Identifier to invalidate |

## Verification
The embedded assertions check several rules on every cycle: each request gets exactly one answer on the following cycle, an abort never appears without a hit, the page offset always passes through, and a refill request only accompanies a miss. They also check that a full invalidate leaves nothing valid, that an invalidate cycle never adds an entry, and that a fill lands in a free slot whenever one exists. Only the bench scenarios can show the translation results: identifier and global matching, masking for each page size, the permission outcomes per access kind, the rotating eviction order, and the fact that random replacement displaces exactly one mapping.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  localparam int VA_W     = 32;
  localparam int PG_SHIFT = 12;
  localparam int VPN_W    = VA_W - PG_SHIFT;
  localparam int ASID_W   = 8;
  localparam int PERM_W   = 4;

  typedef enum logic [1:0] {PG_4K = 2'd0, PG_64K = 2'd1, PG_1M = 2'd2, PG_16M = 2'd3} pg_size_e;
  typedef enum logic [1:0] {ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_FETCH = 2'd2, ACC_LOAD2 = 2'd3} acc_e;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  ppn;
    pg_size_e          size;
    logic [ASID_W-1:0] asid;
    logic              nonsec;
    logic              glb;
    logic [PERM_W-1:0] perm;
  } tlb_entry_t;

  // Each size step is 16x the previous one, so four more page-number bits drop out.
  function automatic logic [VPN_W-1:0] size_mask(pg_size_e s);
    return {VPN_W{1'b1}} << (4 * int'(s));
  endfunction

  function automatic logic perm_fail(logic [PERM_W-1:0] p, acc_e k, logic priv);
    logic bad;
    case (k)
      ACC_STORE: bad = !p[1];
      ACC_FETCH: bad = p[2];
      default:   bad = !p[0];
    endcase
    if (p[3] && !priv) bad = 1'b1;
    return bad;
  endfunction
endpackage

// File: rtl/utlb_match.sv
module utlb_match
  import utlb_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  tlb_entry_t        tbl [ENTRIES],
  input  logic [ENTRIES-1:0] vld,
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic [ASID_W-1:0] q_asid,
  input  logic              q_nonsec,
  output logic [ENTRIES-1:0] hit_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [VPN_W-1:0] msk;
    logic             page_eq, id_eq;
    assign msk     = size_mask(tbl[g].size);
    assign page_eq = ((tbl[g].vpn ^ q_vpn) & msk) == '0;
    assign id_eq   = (tbl[g].glb || (tbl[g].asid == q_asid)) && (tbl[g].nonsec == q_nonsec);
    assign hit_vec[g] = vld[g] && page_eq && id_eq;
  end
endmodule

// File: rtl/utlb_victim.sv
module utlb_victim #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LFSR_W = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rand_mode,
  input  logic [ENTRIES-1:0] vld,
  input  logic               fill_take,
  output logic [IDX_W-1:0]   victim
);
  function automatic logic [LFSR_W-1:0] tap_mask(int w);
    case (w)
      3:       return LFSR_W'(3'b110);
      4:       return LFSR_W'(4'b1100);
      5:       return LFSR_W'(5'b10100);
      6:       return LFSR_W'(6'b110000);
      7:       return LFSR_W'(7'b1100000);
      8:       return LFSR_W'(8'b10111000);
      default: return LFSR_W'(9'b100010000);
    endcase
  endfunction
  localparam logic [LFSR_W-1:0] TAPS = tap_mask(LFSR_W);

  logic [IDX_W-1:0]  rr_ptr, free_idx, rnd_idx;
  logic [LFSR_W-1:0] lfsr;
  logic              has_free;

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign rnd_idx = (int'(lfsr[IDX_W-1:0]) < ENTRIES) ? lfsr[IDX_W-1:0] : rr_ptr;
  assign victim  = has_free ? free_idx : (rand_mode ? rnd_idx : rr_ptr);

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr   <= LFSR_W'(1);
      rr_ptr <= '0;
    end else begin
      lfsr <= {lfsr[LFSR_W-2:0], ^(lfsr & TAPS)};
      if (fill_take && !has_free && !rand_mode)
        rr_ptr <= (int'(rr_ptr) == ENTRIES - 1) ? '0 : rr_ptr + 1'b1;
    end
  end

  assert_free_slot_first_R7: assert property (@(posedge clk) disable iff (rst)
    (vld != '1) |-> !vld[victim]);
  assert_rr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !fill_take |=> $stable(rr_ptr));
  assert_lfsr_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0);
endmodule

// File: rtl/utlb_top.sv
module utlb_top
  import utlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_rand_repl,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_nonsec,
  input  logic [1:0]        lk_kind,
  input  logic              lk_priv,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_abort,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic              rf_req,
  output logic [VA_W-1:0]   rf_req_vaddr,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [VPN_W-1:0]  fill_ppn,
  input  logic [1:0]        fill_size,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              fill_nonsec,
  input  logic              fill_global,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              inv_all,
  input  logic              inv_asid_valid,
  input  logic [ASID_W-1:0] inv_asid
);
  tlb_entry_t         tbl [ENTRIES];
  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] hit_vec;
  logic [IDX_W-1:0]   victim, sel;
  logic               any_inv, fill_take, hit_any;
  logic [VPN_W-1:0]   q_vpn, out_frame, m;
  tlb_entry_t         hit_e;

  assign q_vpn     = lk_vaddr[VA_W-1:PG_SHIFT];
  assign any_inv   = inv_all || inv_asid_valid;
  assign fill_take = fill_valid && !any_inv;

  utlb_match #(.ENTRIES(ENTRIES)) u_match (
    .tbl(tbl), .vld(vld), .q_vpn(q_vpn), .q_asid(lk_asid),
    .q_nonsec(lk_nonsec), .hit_vec(hit_vec)
  );

  utlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst(rst), .rand_mode(cfg_rand_repl), .vld(vld),
    .fill_take(fill_take), .victim(victim)
  );

  // Lowest-numbered matching slot wins if software ever loads overlapping pages.
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) sel = IDX_W'(i);
  end
  assign hit_any   = |hit_vec;
  assign hit_e     = tbl[sel];
  assign m         = size_mask(hit_e.size);
  assign out_frame = (hit_e.ppn & m) | (q_vpn & ~m);

  // Entry payload: written only by fills, no reset needed.
  always_ff @(posedge clk) begin
    if (fill_take) begin
      tbl[victim].vpn    <= fill_vpn;
      tbl[victim].ppn    <= fill_ppn;
      tbl[victim].size   <= pg_size_e'(fill_size);
      tbl[victim].asid   <= fill_asid;
      tbl[victim].nonsec <= fill_nonsec;
      tbl[victim].glb    <= fill_global;
      tbl[victim].perm   <= fill_perm;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || inv_all) begin
      vld <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (inv_asid_valid && !tbl[i].glb && tbl[i].asid == inv_asid)
          vld[i] <= 1'b0;
        else if (fill_take && victim == IDX_W'(i))
          vld[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_abort    <= 1'b0;
      rsp_paddr    <= '0;
      rf_req       <= 1'b0;
      rf_req_vaddr <= '0;
    end else begin
      rsp_valid    <= lk_valid;
      rsp_hit      <= lk_valid && hit_any;
      rsp_abort    <= lk_valid && hit_any && perm_fail(hit_e.perm, acc_e'(lk_kind), lk_priv);
      rsp_paddr    <= (lk_valid && hit_any) ? {out_frame, lk_vaddr[PG_SHIFT-1:0]} : '0;
      rf_req       <= lk_valid && !hit_any;
      rf_req_vaddr <= lk_vaddr;
    end
  end

  assert_answer_next_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);
  assert_no_spurious_answer_R2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);
  assert_refill_only_on_miss_R2: assert property (@(posedge clk) disable iff (rst)
    rf_req |-> (rsp_valid && !rsp_hit));
  assert_abort_needs_hit_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_abort |-> rsp_hit);
  assert_offset_passthru_R5: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && hit_any) |=> rsp_paddr[PG_SHIFT-1:0] == $past(lk_vaddr[PG_SHIFT-1:0]));
  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> vld == '0);
  assert_inv_drops_fill_R12: assert property (@(posedge clk) disable iff (rst)
    any_inv |=> (vld & ~$past(vld)) == '0);
endmodule

// File: tb/tb_utlb_top.sv
module tb_utlb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1, cfg_rand_repl = 1'b0;
  logic        lk_valid = 1'b0, lk_nonsec = 1'b0, lk_priv = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic [1:0]  lk_kind = '0;
  logic        rsp_valid, rsp_hit, rsp_abort, rf_req;
  logic [31:0] rsp_paddr, rf_req_vaddr;
  logic        fill_valid = 1'b0, fill_nonsec = 1'b0, fill_global = 1'b0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic [1:0]  fill_size = '0;
  logic [7:0]  fill_asid = '0, inv_asid = '0;
  logic [3:0]  fill_perm = '0;
  logic        inv_all = 1'b0, inv_asid_valid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  utlb_top dut (.*);

  typedef struct {
    bit          chk;
    bit          hit;
    bit          abt;
    logic [31:0] pa;
    logic [31:0] va;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0, dc_hits = 0;
  bit   done = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expectation per answered lookup.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (q.size() == 0) begin
        check("R2 unexpected response", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.chk) begin
          check({e.tag, " hit"}, 32'(rsp_hit), 32'(e.hit));
          check({e.tag, " abort"}, 32'(rsp_abort), 32'(e.abt));
          check({e.tag, " R2 refill req"}, 32'(rf_req), 32'(!e.hit));
          if (e.hit) check({e.tag, " paddr"}, rsp_paddr, e.pa);
          else       check({e.tag, " R2 refill addr"}, rf_req_vaddr, e.va);
        end else if (rsp_hit) begin
          dc_hits++;
        end
      end
    end
  end

  task automatic clear_ins();
    lk_valid = 0; fill_valid = 0; inv_all = 0; inv_asid_valid = 0;
  endtask

  task automatic look(logic [31:0] va, logic [7:0] asid, logic ns, logic [1:0] kind,
                      logic priv, bit chk, bit hit, bit abt, logic [31:0] pa, string tag);
    exp_t e;
    @(negedge clk);
    clear_ins();
    lk_valid = 1; lk_vaddr = va; lk_asid = asid; lk_nonsec = ns; lk_kind = kind; lk_priv = priv;
    e.chk = chk; e.hit = hit; e.abt = abt; e.pa = pa; e.va = va; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic fill(logic [19:0] vpn, logic [19:0] ppn, logic [1:0] sz, logic [7:0] asid,
                      logic ns, logic glb, logic [3:0] perm, bit flush);
    @(negedge clk);
    clear_ins();
    fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn; fill_size = sz; fill_asid = asid;
    fill_nonsec = ns; fill_global = glb; fill_perm = perm; inv_all = flush;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    clear_ins();
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 rsp_valid after reset", 32'(rsp_valid), 0);
    check("R1 rf_req after reset", 32'(rf_req), 0);
    look(32'h0000_1000, 8'd0, 0, 2'd0, 1, 1, 0, 0, 0, "R1 empty miss");

    // R3: identifier and secure-tag matching
    fill(20'h00010, 20'h00ABC, 2'd0, 8'd5, 0, 0, 4'b0011, 0);
    look(32'h0001_0234, 8'd5, 0, 2'd0, 0, 1, 1, 0, 32'h00AB_C234, "R3 same asid");
    look(32'h0001_0234, 8'd6, 0, 2'd0, 0, 1, 0, 0, 0, "R3 other asid");
    look(32'h0001_0234, 8'd5, 1, 2'd0, 0, 1, 0, 0, 0, "R3 other ns");
    // R4: global entry
    fill(20'h00020, 20'h00300, 2'd0, 8'd9, 0, 1, 4'b0001, 0);
    look(32'h0002_00F0, 8'd77, 0, 2'd0, 0, 1, 1, 0, 32'h0030_00F0, "R4 global any asid");
    look(32'h0002_00F0, 8'd77, 1, 2'd0, 0, 1, 0, 0, 0, "R4 global ns mismatch");
    // R5: page sizes
    fill(20'h12340, 20'h56780, 2'd1, 8'd5, 0, 0, 4'b0001, 0);
    fill(20'h20000, 20'h30000, 2'd2, 8'd3, 0, 0, 4'b0001, 0);
    fill(20'h40000, 20'h7F000, 2'd3, 8'd3, 0, 0, 4'b0001, 0);
    look(32'h1234_ABCD, 8'd5, 0, 2'd0, 0, 1, 1, 0, 32'h5678_ABCD, "R5 64K");
    look(32'h1235_0000, 8'd5, 0, 2'd0, 0, 1, 0, 0, 0, "R5 64K boundary");
    look(32'h200F_1234, 8'd3, 0, 2'd0, 0, 1, 1, 0, 32'h300F_1234, "R5 1M");
    look(32'h40AB_CDEF, 8'd3, 0, 2'd0, 0, 1, 1, 0, 32'h7FAB_CDEF, "R5 16M");
    // R6: permissions
    fill(20'h00050, 20'h00060, 2'd0, 8'd5, 0, 0, 4'b1101, 0);
    look(32'h0001_0010, 8'd5, 0, 2'd1, 0, 1, 1, 0, 32'h00AB_C010, "R6 store ok");
    look(32'h0001_0010, 8'd5, 0, 2'd2, 0, 1, 1, 0, 32'h00AB_C010, "R6 fetch ok");
    look(32'h1234_0008, 8'd5, 0, 2'd1, 0, 1, 1, 1, 32'h5678_0008, "R6 store to read-only");
    look(32'h0005_0004, 8'd5, 0, 2'd3, 1, 1, 1, 0, 32'h0006_0004, "R6 priv load ok");
    look(32'h0005_0004, 8'd5, 0, 2'd0, 0, 1, 1, 1, 32'h0006_0004, "R6 user to priv-only");
    look(32'h0005_0004, 8'd5, 0, 2'd2, 1, 1, 1, 1, 32'h0006_0004, "R6 fetch execute-never");
    look(32'h0009_0000, 8'd5, 0, 2'd1, 0, 1, 0, 0, 0, "R6 miss no abort");
    // R11: invalidate by identifier 5
    @(negedge clk);
    clear_ins();
    inv_asid_valid = 1; inv_asid = 8'd5;
    look(32'h0001_0234, 8'd5, 0, 2'd0, 0, 1, 0, 0, 0, "R11 asid5 gone");
    look(32'h0005_0004, 8'd5, 0, 2'd0, 1, 1, 0, 0, 0, "R11 asid5 priv gone");
    look(32'h0002_0000, 8'd5, 0, 2'd0, 0, 1, 1, 0, 32'h0030_0000, "R11 global kept");
    look(32'h2000_0000, 8'd3, 0, 2'd0, 0, 1, 1, 0, 32'h3000_0000, "R11 asid3 kept");
    // R10 / R12: flush with a colliding fill
    fill(20'h00300, 20'h00400, 2'd0, 8'd1, 0, 0, 4'b0011, 1);
    look(32'h0030_0000, 8'd1, 0, 2'd0, 0, 1, 0, 0, 0, "R12 fill dropped");
    look(32'h0002_0000, 8'd1, 0, 2'd0, 0, 1, 0, 0, 0, "R10 global flushed");
    look(32'h2000_0000, 8'd3, 0, 2'd0, 0, 1, 0, 0, 0, "R10 1M flushed");
    // R7: fill all free slots, none overwritten
    for (int i = 0; i < 32; i++)
      fill(20'h00100 + 20'(i), 20'h00800 + 20'(i), 2'd0, 8'd1, 0, 0, 4'b0011, 0);
    look(32'h0010_0000, 8'd1, 0, 2'd0, 0, 1, 1, 0, 32'h0080_0000, "R7 immediate use");
    for (int i = 0; i < 32; i++)
      look(32'h0010_0000 + (32'(i) << 12), 8'd1, 0, 2'd0, 0, 1, 1, 0,
           32'h0080_0000 + (32'(i) << 12), "R7 all slots kept");
    // R8: rotating eviction from slot 0
    fill(20'h00200, 20'h00900, 2'd0, 8'd1, 0, 0, 4'b0011, 0);
    look(32'h0010_0000, 8'd1, 0, 2'd0, 0, 1, 0, 0, 0, "R8 slot0 evicted");
    look(32'h0010_1000, 8'd1, 0, 2'd0, 0, 1, 1, 0, 32'h0080_1000, "R8 slot1 kept");
    fill(20'h00201, 20'h00901, 2'd0, 8'd1, 0, 0, 4'b0011, 0);
    look(32'h0010_1000, 8'd1, 0, 2'd0, 0, 1, 0, 0, 0, "R8 slot1 evicted");
    look(32'h0020_0000, 8'd1, 0, 2'd0, 0, 1, 1, 0, 32'h0090_0000, "R8 new first kept");
    look(32'h0020_1000, 8'd1, 0, 2'd0, 0, 1, 1, 0, 32'h0090_1000, "R8 new second");
    // R9: random replacement displaces exactly one
    @(negedge clk);
    clear_ins();
    cfg_rand_repl = 1;
    fill(20'h00400, 20'h00A00, 2'd0, 8'd1, 0, 0, 4'b0011, 0);
    idle(2);
    dc_hits = 0;
    for (int i = 2; i < 32; i++)
      look(32'h0010_0000 + (32'(i) << 12), 8'd1, 0, 2'd0, 0, 0, 0, 0, 0, "R9");
    look(32'h0020_0000, 8'd1, 0, 2'd0, 0, 0, 0, 0, 0, "R9");
    look(32'h0020_1000, 8'd1, 0, 2'd0, 0, 0, 0, 0, 0, "R9");
    look(32'h0040_0000, 8'd1, 0, 2'd0, 0, 1, 1, 0, 32'h00A0_0000, "R9 new entry hits");
    idle(3);
    check("R9 survivors of random eviction", 32'(dc_hits), 32'd31);
    check("R2 queue drained", 32'(q.size()), 32'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule